// File: doc/BRIEF.md
# Cache-Status Invalidation Filter

This block sits on a shared-memory node board between the inter-node update bus and the local processor. It holds a single flag per memory block recording whether that block might currently live in the processor cache. A local read marks the block as possibly cached. An update arriving from another node is checked against the flag. The block raises an invalidation request toward the processor only when the flag is set. An update to a block that was never read, or was already invalidated, is dropped without disturbing the cache.

Both input ports carry block indices, not byte addresses. The invalidation request leaves through a valid/ready channel. While a request is outstanding, the remote update port deasserts its ready, so the one request register never has to queue. A saturating counter reports how many updates were filtered out.

Top module: `inval_filter`

## Requirements
- R1: After synchronous reset every block flag is clear, `inv_valid` is low, `wr_ready` is high and `sup_count` is zero, so any remote update before a local read produces no invalidation.
- R2: A local read (`rd_valid` high) sets the flag of block `rd_blk`; a later accepted remote update to that block produces an invalidation.
- R3: An accepted remote update (`wr_valid` and `wr_ready` high) to a block whose flag is clear produces no invalidation and increments `sup_count` by one.
- R4: An accepted remote update to a block whose flag is set raises `inv_valid` in the next cycle with `inv_blk` equal to that block. The flag is cleared when the request is accepted (`inv_valid` and `inv_ready` high), so a second update to the same block is filtered.
- R5: While `inv_valid` is high and `inv_ready` is low, `inv_valid` stays high, `inv_blk` stays unchanged and `wr_ready` is low.
- R6: When a local read and an accepted remote update name the same block in the same cycle, the update is judged on the flag value from before that cycle, and the flag is set afterwards.
- R7: A local read of the block named by a pending invalidation keeps that block's flag set once the request is accepted.
- R8: Flags are independent: a read of one block does not cause an invalidation for an update to a different block.
- R9: `sup_count` is `CNT_W` bits wide and saturates at its all-ones value instead of wrapping.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rd_valid | input | 1 | Local read of a block this cycle |
| rd_blk | input | IDX_W | Block index of the local read |
| wr_valid | input | 1 | Remote update offered |
| wr_blk | input | IDX_W | Block index of the remote update |
| wr_ready | output | 1 | Remote update accepted this cycle when high |
| inv_valid | output | 1 | Invalidation request pending |
| inv_blk | output | IDX_W | Block index to invalidate |
| inv_ready | input | 1 | Processor accepts the invalidation |
| sup_count | output | CNT_W | Saturating count of filtered updates |

IDX_W is $clog2(N_BLOCKS).

## Verification
The bench builds the block with 16 blocks and a 4-bit counter. With these values a sweep of remote updates across most of the array finishes in a few dozen cycles. The counter also reaches its ceiling of 15 inside a short run, so saturation is exercised. The small array still has distinct neighbouring blocks for the independence case. Stalled handshakes and same-cycle read/update collisions are driven explicitly, and every expected invalidation index is compared in order through a queue.

// File: rtl/inval_pkg.sv
package inval_pkg;
  // outcome of the remote update port in one cycle
  typedef enum logic [1:0] {
    WR_IDLE     = 2'd0,
    WR_SUPPRESS = 2'd1,
    WR_ISSUE    = 2'd2
  } wr_outcome_e;
endpackage

// File: rtl/inval_status_bits.sv
module inval_status_bits #(
  parameter int N_BLOCKS = 1024,
  parameter int IDX_W    = $clog2(N_BLOCKS)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             set_en,
  input  logic [IDX_W-1:0] set_idx,
  input  logic             clr_en,
  input  logic [IDX_W-1:0] clr_idx,
  input  logic [IDX_W-1:0] look_idx,
  output logic             look_bit
);
  logic [N_BLOCKS-1:0] flags;

  // one flop per block; a set in the same cycle wins over a clear
  for (genvar g = 0; g < N_BLOCKS; g++) begin : g_flag
    always_ff @(posedge clk) begin
      if (rst)
        flags[g] <= 1'b0;
      else if (set_en && set_idx == IDX_W'(g))
        flags[g] <= 1'b1;
      else if (clr_en && clr_idx == IDX_W'(g))
        flags[g] <= 1'b0;
    end
  end

  assign look_bit = flags[look_idx];
endmodule

// File: rtl/inval_req_slot.sv
module inval_req_slot #(
  parameter int IDX_W = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             issue,
  input  logic [IDX_W-1:0] issue_idx,
  input  logic             rd_valid,
  input  logic [IDX_W-1:0] rd_idx,
  input  logic             req_ready,
  output logic             req_valid,
  output logic [IDX_W-1:0] req_idx,
  output logic             clear_flag
);
  logic reread;

  always_ff @(posedge clk) begin
    if (rst) begin
      req_valid <= 1'b0;
      req_idx   <= '0;
      reread    <= 1'b0;
    end else if (issue) begin
      req_valid <= 1'b1;
      req_idx   <= issue_idx;
      reread    <= rd_valid && (rd_idx == issue_idx);
    end else if (req_valid && req_ready) begin
      req_valid <= 1'b0;
      reread    <= 1'b0;
    end else if (req_valid && rd_valid && rd_idx == req_idx) begin
      reread    <= 1'b1;
    end
  end

  // a read that followed the update keeps the block marked as cached
  assign clear_flag = req_valid && req_ready && !reread;
endmodule

// File: rtl/inval_sup_counter.sv
module inval_sup_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             bump,
  output logic [CNT_W-1:0] count
);
  localparam logic [CNT_W-1:0] CEIL = '1;

  always_ff @(posedge clk) begin
    if (rst)
      count <= '0;
    else if (bump && count != CEIL)
      count <= count + 1'b1;
  end
endmodule

// File: rtl/inval_filter.sv
module inval_filter
  import inval_pkg::*;
#(
  parameter int N_BLOCKS = 1024,
  parameter int CNT_W    = 16,
  localparam int IDX_W   = $clog2(N_BLOCKS)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             rd_valid,
  input  logic [IDX_W-1:0] rd_blk,
  input  logic             wr_valid,
  input  logic [IDX_W-1:0] wr_blk,
  output logic             wr_ready,
  output logic             inv_valid,
  output logic [IDX_W-1:0] inv_blk,
  input  logic             inv_ready,
  output logic [CNT_W-1:0] sup_count
);
  logic        cached;
  logic        clear_flag;
  wr_outcome_e outcome;

  assign wr_ready = !inv_valid;

  always_comb begin
    if (!(wr_valid && wr_ready))
      outcome = WR_IDLE;
    else if (cached)
      outcome = WR_ISSUE;
    else
      outcome = WR_SUPPRESS;
  end

  inval_status_bits #(.N_BLOCKS(N_BLOCKS), .IDX_W(IDX_W)) u_bits (
    .clk      (clk),
    .rst      (rst),
    .set_en   (rd_valid),
    .set_idx  (rd_blk),
    .clr_en   (clear_flag),
    .clr_idx  (inv_blk),
    .look_idx (wr_blk),
    .look_bit (cached)
  );

  inval_req_slot #(.IDX_W(IDX_W)) u_slot (
    .clk        (clk),
    .rst        (rst),
    .issue      (outcome == WR_ISSUE),
    .issue_idx  (wr_blk),
    .rd_valid   (rd_valid),
    .rd_idx     (rd_blk),
    .req_ready  (inv_ready),
    .req_valid  (inv_valid),
    .req_idx    (inv_blk),
    .clear_flag (clear_flag)
  );

  inval_sup_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk   (clk),
    .rst   (rst),
    .bump  (outcome == WR_SUPPRESS),
    .count (sup_count)
  );
endmodule

// File: rtl/inval_filter_chk.sv
module inval_filter_chk #(
  parameter int IDX_W = 10,
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst,
  input logic             wr_valid,
  input logic             wr_ready,
  input logic             inv_valid,
  input logic [IDX_W-1:0] inv_blk,
  input logic             inv_ready,
  input logic [CNT_W-1:0] sup_count
);
  // R1
  reset_state_chk: assert property (@(posedge clk)
    rst |=> (!inv_valid && sup_count == '0));

  // R5
  held_request_chk: assert property (@(posedge clk) disable iff (rst)
    (inv_valid && !inv_ready) |=> (inv_valid && $stable(inv_blk)));

  // R5
  stall_updates_chk: assert property (@(posedge clk) disable iff (rst)
    inv_valid |-> !wr_ready);

  // R3
  count_needs_update_chk: assert property (@(posedge clk) disable iff (rst)
    !(wr_valid && wr_ready) |=> $stable(sup_count));

  // R4
  issue_not_counted_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(inv_valid) |-> $stable(sup_count));
endmodule

bind inval_filter inval_filter_chk #(.IDX_W(IDX_W), .CNT_W(CNT_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .wr_valid  (wr_valid),
  .wr_ready  (wr_ready),
  .inv_valid (inv_valid),
  .inv_blk   (inv_blk),
  .inv_ready (inv_ready),
  .sup_count (sup_count)
);

// File: tb/inval_filter_bench.sv
module inval_filter_bench;
  localparam int PERIOD = 10;
  localparam int NB     = 16;
  localparam int CW     = 4;
  localparam int IW     = $clog2(NB);
  localparam int CMAX   = (1 << CW) - 1;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          rd_valid = 1'b0;
  logic [IW-1:0] rd_blk = '0;
  logic          wr_valid = 1'b0;
  logic [IW-1:0] wr_blk = '0;
  logic          wr_ready;
  logic          inv_valid;
  logic [IW-1:0] inv_blk;
  logic          inv_ready = 1'b1;
  logic [CW-1:0] sup_count;

  int checks = 0;
  int errors = 0;
  int exp_sup = 0;
  int exp_q[$];

  always #(PERIOD/2) clk = ~clk;

  inval_filter #(.N_BLOCKS(NB), .CNT_W(CW)) u_inval_filter (
    .clk(clk), .rst(rst), .rd_valid(rd_valid), .rd_blk(rd_blk),
    .wr_valid(wr_valid), .wr_blk(wr_blk), .wr_ready(wr_ready),
    .inv_valid(inv_valid), .inv_blk(inv_blk), .inv_ready(inv_ready),
    .sup_count(sup_count)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // inputs change 1 time unit after the falling edge
  task automatic step();
    @(negedge clk);
    #1;
  endtask

  // monitor: pops the scoreboard for each accepted invalidation
  always @(negedge clk) begin
    #2;
    if (!rst && inv_valid && inv_ready) begin
      if (exp_q.size() == 0) begin
        chk(1'b0, "R3 unexpected invalidation blk", int'(inv_blk), -1);
      end else begin
        int e;
        e = exp_q.pop_front();
        chk(int'(inv_blk) == e, "R4 invalidation blk", int'(inv_blk), e);
      end
    end
  end

  task automatic bump_model();
    if (exp_sup < CMAX) exp_sup++;
  endtask

  task automatic do_read(input int b);
    rd_valid = 1'b1; rd_blk = IW'(b);
    step();
    rd_valid = 1'b0;
  endtask

  task automatic do_write(input int b, input bit expect_inv);
    while (!wr_ready) step();
    wr_valid = 1'b1; wr_blk = IW'(b);
    if (expect_inv) exp_q.push_back(b); else bump_model();
    step();
    wr_valid = 1'b0;
  endtask

  task automatic do_both(input int b, input bit expect_inv);
    while (!wr_ready) step();
    rd_valid = 1'b1; rd_blk = IW'(b);
    wr_valid = 1'b1; wr_blk = IW'(b);
    if (expect_inv) exp_q.push_back(b); else bump_model();
    step();
    rd_valid = 1'b0; wr_valid = 1'b0;
  endtask

  task automatic drain(input string tag);
    for (int i = 0; i < 20 && (exp_q.size() != 0 || inv_valid); i++) step();
    step();
    chk(exp_q.size() == 0, tag, exp_q.size(), 0);
  endtask

  initial begin
    #(PERIOD * 200000);
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    step(); step();
    rst = 1'b0;
    step();
    // R1 reset state
    chk(inv_valid == 1'b0, "R1 inv_valid after reset", int'(inv_valid), 0);
    chk(wr_ready == 1'b1, "R1 wr_ready after reset", int'(wr_ready), 1);
    chk(sup_count == '0, "R1 sup_count after reset", int'(sup_count), 0);

    // R1/R3 every flag starts clear: all updates filtered
    for (int b = 0; b < 14; b++) do_write(b, 1'b0);
    drain("R1 no invalidation from clear flags");
    chk(int'(sup_count) == exp_sup, "R3 sup_count after sweep", int'(sup_count), exp_sup);

    // R2/R4 read marks, update invalidates, flag then cleared
    do_read(3);
    do_write(3, 1'b1);
    drain("R2 invalidation after read");
    do_write(3, 1'b0);
    drain("R4 flag cleared after handshake");
    chk(int'(sup_count) == exp_sup, "R4 second update filtered", int'(sup_count), exp_sup);

    // R9 saturation
    do_write(5, 1'b0);
    do_write(6, 1'b0);
    drain("R9 no invalidation");
    chk(int'(sup_count) == CMAX, "R9 counter saturates", int'(sup_count), CMAX);

    // R8 independence
    do_read(7);
    do_write(8, 1'b0);
    drain("R8 other block untouched");
    do_write(7, 1'b1);
    drain("R8 read block invalidated");

    // R5 backpressure
    do_read(9);
    inv_ready = 1'b0;
    do_write(9, 1'b1);
    for (int i = 0; i < 3; i++) begin
      chk(inv_valid == 1'b1, "R5 inv_valid held", int'(inv_valid), 1);
      chk(int'(inv_blk) == 9, "R5 inv_blk stable", int'(inv_blk), 9);
      chk(wr_ready == 1'b0, "R5 wr_ready low", int'(wr_ready), 0);
      step();
    end
    inv_ready = 1'b1;
    drain("R5 request released");
    chk(wr_ready == 1'b1, "R5 wr_ready back", int'(wr_ready), 1);

    // R6 same-cycle read and update, flag clear beforehand
    do_both(12, 1'b0);
    drain("R6 old flag clear: filtered");
    do_write(12, 1'b1);
    drain("R6 flag set by concurrent read");
    // R6 flag set beforehand
    do_read(4);
    do_both(4, 1'b1);
    drain("R6 old flag set: invalidated");
    do_write(4, 1'b1);
    drain("R6 flag kept after concurrent read");

    // R7 read during pending invalidation
    do_read(10);
    inv_ready = 1'b0;
    do_write(10, 1'b1);
    do_read(10);
    step();
    inv_ready = 1'b1;
    drain("R7 pending request accepted");
    do_write(10, 1'b1);
    drain("R7 flag kept after reread");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule